// File: doc/BRIEF.md
# SAR Conversion Sequencer

This block is the synchronous control core of a successive-approximation converter with a 12-bit result. Two asynchronous control pins drive it. The first is a start strobe: its rising edge opens the sampling window and its falling edge closes it. The second is an active-low select. Both pins pass through synchronisers, and edge detectors watch their synchronised levels. From those edges the block decides when acquisition begins and when conversion begins. Either pin can trigger each event, provided the other pin is at the right level.

Once a conversion starts, the block runs one bit trial per clock, most significant bit first. It drives the trial code to an external DAC and comparator and keeps or clears each bit according to the comparator answer. The busy output covers the whole conversion. The finished code goes into a result latch, which changes only when a conversion completes or is aborted. An abort loads a fixed marker code. If the select is low and the strobe is already high when the last trial ends, a new acquisition starts in the same cycle that busy drops, which allows back-to-back operation.

Top module: `sar_conv_seq`

## Requirements
- R1: While idle, a synchronised rising edge of `convStartIn` with `chipSelN` low starts acquisition (`sampling` goes to 1). The same edge with `chipSelN` high has no effect, and `sampling` stays 0.
- R2: While idle, a synchronised falling edge of `chipSelN` with `convStartIn` high starts acquisition.
- R3: During acquisition, a conversion starts on a falling edge of `convStartIn` while `chipSelN` is low, or on a falling edge of `chipSelN` while `convStartIn` is low. A falling edge of `convStartIn` while `chipSelN` is high is ignored, and `sampling` stays 1.
- R4: `busy` rises in the cycle after a conversion start is accepted and stays high for exactly RES_BITS (12) clock cycles. `busy` and `sampling` are never both 1.
- R5: The result is straight binary. Trials run MSB first, and each trial keeps its bit when `cmpIn` is 1 (input at or above `trialCode`). An input equal to code 0 yields 12'h000, half scale yields 12'h800 and full scale yields 12'hFFF.
- R6: A falling edge of `chipSelN` while `busy` is 1 and `convStartIn` is high aborts the conversion. In that case `busy` falls, `sampling` stays 0 and `resultOut` becomes 12'hFE0.
- R7: If `chipSelN` is low and `convStartIn` is high when the last trial completes, `sampling` becomes 1 in the same cycle that `busy` becomes 0.
- R8: `resultOut` changes only on a completed or aborted conversion. During a conversion it keeps the previous result.
- R9: A conversion-start edge that arrives fewer than MIN_ACQ cycles after acquisition began is ignored: `busy` stays 0 and `sampling` stays 1. It sets `acqErr`, which stays set until reset.
- R10: During reset, `busy`, `sampling` and `acqErr` are 0 and `resultOut` is 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| convStartIn | input | 1 | Asynchronous start strobe: rising edge samples, falling edge converts |
| chipSelN | input | 1 | Asynchronous active-low select |
| cmpIn | input | 1 | Comparator answer, 1 when the input is at or above trialCode |
| trialCode | output | 12 | Current trial code driven to the DAC |
| busy | output | 1 | High for the duration of a conversion |
| sampling | output | 1 | High while acquisition is open |
| resultOut | output | 12 | Latched conversion result, or the abort marker |
| acqErr | output | 1 | Sticky flag for an early conversion-start edge |

## Verification
The bench converts a table of input levels that includes the all-zero, half-scale and full-scale codes, plus alternating bit patterns. A trial polarity or bit order that is wrong shows up directly as a wrong code. It counts the busy cycles of each conversion and reads `resultOut` halfway through one. A latch that tracked the working register would leak partial codes there. Directed cases cover:
- an abort issued through the select, where a wrong design would finish with a real code or keep busy high;
- the back-to-back hand-off, where a design that waited would show a cycle with neither busy nor sampling;
- an over-early start edge, which must leave the block sampling with the error flag raised;
- the ignored edges of each pin when the other pin has the wrong level.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2
  } seqStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // start conversion: seed MSB trial
    logic step;    // resolve current trial bit
    logic finish;  // last trial, latch result
    logic abort;   // abort, latch marker code
  } sarStrobeT;

endpackage

// File: rtl/sar_seq_sync.sv
module sar_seq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[0] <= RST_VAL;
          else       chain[0] <= asyncIn;
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= RST_VAL;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS = 12,
  parameter int MIN_ACQ  = 4,
  localparam int ACQ_W   = $clog2(MIN_ACQ + 2),
  localparam int RUN_W   = $clog2(RES_BITS + 2)
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      convLvl,   // synchronised start strobe
  input  logic      selNLvl,   // synchronised active-low select
  input  logic      lastTrial,
  output sarStrobeT strb,
  output logic      busy,
  output logic      sampling,
  output logic      acqErr
);

  seqStateT         state, nextState;
  logic             convPrev, selNPrev;
  logic [ACQ_W-1:0] acqCnt;
  logic             convRise, convFall, selFall, selected;
  logic             acqStart, convStart, earlyStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      convPrev <= 1'b0;
      selNPrev <= 1'b1;
    end else begin
      convPrev <= convLvl;
      selNPrev <= selNLvl;
    end
  end

  assign convRise  = convLvl & ~convPrev;
  assign convFall  = ~convLvl & convPrev;
  assign selFall   = ~selNLvl & selNPrev;
  assign selected  = ~selNLvl;
  assign acqStart  = (convRise && selected) || (selFall && convLvl);
  assign convStart = (convFall && selected) || (selFall && !convLvl);

  always_comb begin
    nextState  = state;
    strb       = '0;
    earlyStart = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (acqStart) nextState = ST_ACQ;
      end
      ST_ACQ: begin
        if (convStart) begin
          if (int'(acqCnt) >= MIN_ACQ) begin
            nextState = ST_CONV;
            strb.load = 1'b1;
          end else begin
            earlyStart = 1'b1;
          end
        end
      end
      ST_CONV: begin
        if (selFall && convLvl) begin
          strb.abort = 1'b1;
          nextState  = ST_IDLE;
        end else begin
          strb.step = 1'b1;
          if (lastTrial) begin
            strb.finish = 1'b1;
            nextState   = (selected && convLvl) ? ST_ACQ : ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      busy     <= 1'b0;
      sampling <= 1'b0;
      acqErr   <= 1'b0;
      acqCnt   <= '0;
    end else begin
      state    <= nextState;
      busy     <= (nextState == ST_CONV);
      sampling <= (nextState == ST_ACQ);
      if (earlyStart) acqErr <= 1'b1;
      if (nextState == ST_ACQ && state != ST_ACQ)
        acqCnt <= '0;
      else if (state == ST_ACQ && int'(acqCnt) < MIN_ACQ)
        acqCnt <= acqCnt + 1'b1;
    end
  end

  // Busy run-length counter for the checker
  logic [RUN_W-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R4
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(busyRun) <= RES_BITS);

  // R4
  busy_after_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> busy);

  // R4
  busy_samp_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && sampling));

  // R6
  abort_drops_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && selFall && convLvl) |=> (!busy && !sampling));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    acqErr |=> acqErr);

  // R9
  early_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    earlyStart |=> (sampling && !busy && acqErr));

endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int                RES_BITS   = 12,
  parameter logic [RES_BITS-1:0] ABORT_CODE = 12'hFE0
) (
  input  logic                clk,
  input  logic                rstN,
  input  sarStrobeT           strb,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] trialCode,
  output logic [RES_BITS-1:0] resultOut,
  output logic                lastTrial
);

  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] sarReg, trialMask, resolved;

  // Keep the trial bit on a high comparator answer, clear it otherwise
  assign resolved  = cmpIn ? sarReg : (sarReg & ~trialMask);
  assign lastTrial = trialMask[0];
  assign trialCode = sarReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg    <= '0;
      trialMask <= '0;
    end else if (strb.load) begin
      sarReg    <= MSB_ONE;
      trialMask <= MSB_ONE;
    end else if (strb.abort) begin
      trialMask <= '0;
    end else if (strb.step) begin
      sarReg    <= resolved | (trialMask >> 1);
      trialMask <= trialMask >> 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            resultOut <= '0;
    else if (strb.abort)  resultOut <= ABORT_CODE;
    else if (strb.finish) resultOut <= resolved;
  end

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.finish || strb.abort) |=> $stable(resultOut));

  // R5
  msb_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (trialCode == MSB_ONE));

  // R6
  abort_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.abort |=> (resultOut == ABORT_CODE));

  // R5
  mask_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trialMask));

endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_BITS    = 12,
  parameter int MIN_ACQ     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                convStartIn,
  input  logic                chipSelN,
  input  logic                cmpIn,
  output logic [RES_BITS-1:0] trialCode,
  output logic                busy,
  output logic                sampling,
  output logic [RES_BITS-1:0] resultOut,
  output logic                acqErr
);

  logic      convLvl, selNLvl, lastTrial;
  sarStrobeT strb;

  sar_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_syncConv (
    .clk(clk), .rstN(rstN), .asyncIn(convStartIn), .syncOut(convLvl)
  );

  sar_seq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_syncSel (
    .clk(clk), .rstN(rstN), .asyncIn(chipSelN), .syncOut(selNLvl)
  );

  sar_seq_ctrl #(.RES_BITS(RES_BITS), .MIN_ACQ(MIN_ACQ)) u_ctrl (
    .clk(clk), .rstN(rstN), .convLvl(convLvl), .selNLvl(selNLvl),
    .lastTrial(lastTrial), .strb(strb), .busy(busy),
    .sampling(sampling), .acqErr(acqErr)
  );

  sar_seq_dpath #(.RES_BITS(RES_BITS)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpIn(cmpIn),
    .trialCode(trialCode), .resultOut(resultOut), .lastTrial(lastTrial)
  );

endmodule

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    12'h000, 12'h800, 12'hFFF, 12'h001,
    12'hAAA, 12'h555, 12'h7FF, 12'h801
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        convStartIn = 1'b0;
  logic        chipSelN = 1'b1;
  logic [11:0] analogVal = '0;
  logic        cmpIn;
  logic [11:0] trialCode, resultOut;
  logic        busy, sampling, acqErr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [11:0] prevResult = '0;

  // Ideal comparator model: input at or above trial code
  assign cmpIn = (analogVal >= trialCode);

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rstN(rstN), .convStartIn(convStartIn), .chipSelN(chipSelN),
    .cmpIn(cmpIn), .trialCode(trialCode), .busy(busy), .sampling(sampling),
    .resultOut(resultOut), .acqErr(acqErr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Wait for busy to rise, bounded
  task automatic waitBusy(input string req);
    int n = 0;
    while (!busy && n < 30) begin @(negedge clk); n++; end
    check(busy, req, "busy never rose", busy, 1);
  endtask

  // Count busy cycles until it drops; checks result mid-way
  task automatic runBusy(output int len, input logic [11:0] heldVal);
    len = 0;
    while (busy && len < 40) begin
      if (len == 6)
        check(resultOut == heldVal, "R8", "result changed mid-conversion",
              resultOut, heldVal);
      @(negedge clk);
      len++;
    end
  endtask

  task automatic convert(input logic [11:0] val);
    int len;
    analogVal = val;
    convStartIn = 1'b1;
    idle(10);
    check(sampling == 1'b1, "R1", "sampling after strobe rise", sampling, 1);
    convStartIn = 1'b0;
    waitBusy("R3");
    runBusy(len, prevResult);
    check(len == 12, "R4", "busy length", len, 12);
    check(resultOut == val, "R5", "conversion code", resultOut, val);
    prevResult = val;
  endtask

  initial begin : watchdog
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    errors++;
    $display("FAIL R10 watchdog expired actual=%0d expected=done", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int len;
    idle(3);
    // R10 reset state
    check(busy == 0 && sampling == 0, "R10", "busy/sampling in reset",
          {busy, sampling}, 0);
    check(resultOut == 0 && acqErr == 0, "R10", "result/err in reset",
          resultOut, 0);
    rstN = 1'b1;
    idle(3);

    // R1: strobe rise with select high is ignored
    convStartIn = 1'b1;
    idle(8);
    check(sampling == 0, "R1", "rise while deselected", sampling, 0);

    // R2: select fall with strobe high opens acquisition
    chipSelN = 1'b0;
    idle(8);
    check(sampling == 1 && busy == 0, "R2", "select-fall acquisition",
          sampling, 1);

    // R3: strobe fall while deselected is ignored, select fall converts
    chipSelN = 1'b1;
    idle(2);
    convStartIn = 1'b0;
    idle(6);
    check(sampling == 1 && busy == 0, "R3", "strobe fall while deselected",
          {busy, sampling}, 1);
    analogVal = 12'h3C5;
    chipSelN = 1'b0;
    waitBusy("R3");
    runBusy(len, prevResult);
    check(len == 12, "R4", "busy length select path", len, 12);
    check(resultOut == 12'h3C5, "R3", "select-started conversion code",
          resultOut, 12'h3C5);
    prevResult = 12'h3C5;
    idle(3);

    // Main vector table, R5 codes
    for (int i = 0; i < NVEC; i++) begin
      convert(VEC[i]);
      idle(3);
    end

    // R7 back-to-back: strobe raised during conversion, select low
    analogVal = 12'h123;
    convStartIn = 1'b1;
    idle(10);
    convStartIn = 1'b0;
    waitBusy("R7");
    @(negedge clk);
    convStartIn = 1'b1;
    runBusy(len, prevResult);
    check(sampling == 1, "R7", "sampling at busy fall", sampling, 1);
    check(resultOut == 12'h123, "R7", "first back-to-back code",
          resultOut, 12'h123);
    prevResult = 12'h123;
    analogVal = 12'hE01;
    idle(8);
    convStartIn = 1'b0;
    waitBusy("R7");
    runBusy(len, prevResult);
    check(resultOut == 12'hE01, "R7", "second back-to-back code",
          resultOut, 12'hE01);
    prevResult = 12'hE01;
    idle(3);

    // R6 abort: strobe high, select pulsed during conversion
    analogVal = 12'h456;
    convStartIn = 1'b1;
    idle(10);
    convStartIn = 1'b0;
    waitBusy("R6");
    convStartIn = 1'b1;
    idle(1);
    chipSelN = 1'b1;
    idle(1);
    chipSelN = 1'b0;
    runBusy(len, prevResult);
    check(len < 12, "R6", "abort shortens busy", len, 11);
    check(resultOut == 12'hFE0, "R6", "abort marker", resultOut, 12'hFE0);
    check(sampling == 0, "R6", "idle after abort", sampling, 0);
    prevResult = 12'hFE0;
    convStartIn = 1'b0;
    idle(6);

    // R9 early conversion edge
    check(acqErr == 0, "R9", "error clear before early edge", acqErr, 0);
    convStartIn = 1'b1;
    idle(1);
    convStartIn = 1'b0;
    idle(10);
    check(busy == 0 && sampling == 1, "R9", "early edge ignored",
          {busy, sampling}, 1);
    check(acqErr == 1, "R9", "error flag set", acqErr, 1);
    analogVal = 12'h9A3;
    convStartIn = 1'b1;
    idle(4);
    convStartIn = 1'b0;
    waitBusy("R9");
    runBusy(len, prevResult);
    check(resultOut == 12'h9A3, "R9", "later edge converts", resultOut, 12'h9A3);
    check(acqErr == 1, "R9", "error flag sticky", acqErr, 1);

    // R10 reset again clears state
    rstN = 1'b0;
    idle(2);
    check(resultOut == 0 && acqErr == 0 && busy == 0, "R10",
          "state after second reset", resultOut, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule